// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides which interrupt a small 8-bit core takes next. It watches two non-maskable sources and a parameterised set of maskable sources. The non-maskable sources are a reset event and a software trap. Every request is held in a pending latch until the core accepts it.

Each maskable source carries a two-bit software level. A source competes only when its level is strictly above the current level held in the block's two mask bits. Among the competitors, the highest software level wins. The fixed hardware order is used only to break ties between equal levels. The non-maskable sources always compete, at level 3.

The winner is offered to the core on a valid/ready pair, together with its vector index, the level the mask bits will take on entry, and whether the core must stack its registers. A restore input puts back an earlier level when a handler returns.

The offer is live arbitration and is not a held transaction. While `svc_ready` is low, nothing is cleared and the level does not move. The offered vector may change, or `svc_valid` may drop, if the pending set, the enables, the source levels or the current level change. The core samples the vector in the cycle it raises `svc_ready` with `svc_valid` high, and only that cycle counts as service.

Top module: `nipa_top`

## Requirements
- R1: After `rst_n` is released, the reset source is pending and `cur_lvl` is 3, so `svc_valid` is high with `svc_vec` 0, `svc_lvl` 3 and `svc_stack` low.
- R2: Vector indices are 0 for reset, 1 for the trap and 2+i for maskable source i. The winner is the competing source with the highest software level. Ties are broken by hardware order: reset first, then trap, then source 0, source 1, and so on, with the last source lowest.
- R3: Maskable source i competes only if it is pending, `irq_en[i]` is high, and its level `irq_lvl[2i+1:2i]` is strictly greater than `cur_lvl`.
- R4: A request pulse sets that source's pending latch from the next cycle. The latch clears only when the source is accepted (`svc_valid && svc_ready`). A request arriving in the accepting cycle sets the latch again.
- R5: `svc_stack` is low when vector 0 is offered and high for every other vector.
- R6: On acceptance, `cur_lvl` takes the offered `svc_lvl` from the next cycle. This is 3 for reset and the trap, and the source's own level for a maskable source.
- R7: `wake` is high whenever reset or the trap is pending, whatever `cur_lvl` and the enables hold, and a pending non-maskable source is always the one offered.
- R8: `restore_valid` loads `restore_lvl` into `cur_lvl` for the next cycle. If an acceptance happens in the same cycle, the acceptance level wins. Pending requests are re-arbitrated against the new level at once.
- R9: A disabled source keeps its pending request. It competes again as soon as its enable returns.
- R10: While no acceptance occurs, no pending latch is cleared, and `cur_lvl` changes only through restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also raises the reset source |
| reset_req | input | 1 | Warm-reset event, non-maskable |
| trap_req | input | 1 | Software trap event, non-maskable |
| irq_req | input | NUM_SRC | Maskable request pulses |
| irq_en | input | NUM_SRC | Per-source enables |
| irq_lvl | input | 2*NUM_SRC | Two-bit software level per source |
| restore_valid | input | 1 | Load `restore_lvl` into the mask level |
| restore_lvl | input | 2 | Level put back on return from a handler |
| svc_ready | input | 1 | Core accepts the offered vector |
| svc_valid | output | 1 | A source is offered |
| svc_vec | output | VEC_W | Offered vector index |
| svc_lvl | output | 2 | Level the mask bits take on acceptance |
| svc_stack | output | 1 | Core must stack registers before entry |
| wake | output | 1 | Non-maskable source pending; leave halt |
| cur_lvl | output | 2 | Current mask level |

## Verification
The bench goes after equal-level ties, where a design that ranked by hardware order alone would take a lower-level source. It also tests a request whose level equals `cur_lvl`, which a greater-or-equal compare would let through. It raises a request in the very cycle its source is accepted, where a design that cleared after setting would lose the second event. It drives restore and acceptance in the same cycle, and it disables sources while they are pending, which a design that cleared disabled latches would fail to serve later.

// File: rtl/nipa_pkg.sv
package nipa_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP  = 2'd3;
  localparam int   VEC_RST  = 0;
  localparam int   VEC_TRAP = 1;
  localparam int   VEC_BASE = 2;
endpackage

// File: rtl/nipa_pending.sv
module nipa_pending #(
  parameter int          WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q;

  // clear first, then set: a request in the clearing cycle survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= RST_VAL;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nipa_select.sv
module nipa_select
  import nipa_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int VEC_W   = $clog2(NUM_SRC + VEC_BASE)
) (
  input  logic [NUM_SRC+VEC_BASE-1:0] pend_i,
  input  logic [NUM_SRC-1:0]          en_i,
  input  logic [LVL_W*NUM_SRC-1:0]    lvl_i,
  input  lvl_t                        cur_i,
  output logic                        hit_o,
  output logic [VEC_W-1:0]            vec_o,
  output lvl_t                        lvl_o
);
  localparam int TOTAL = NUM_SRC + VEC_BASE;

  logic [TOTAL-1:0] elig;
  lvl_t             ent_lvl [TOTAL];

  // non-maskable entries: always eligible at the top level
  assign elig[VEC_RST]     = pend_i[VEC_RST];
  assign elig[VEC_TRAP]    = pend_i[VEC_TRAP];
  assign ent_lvl[VEC_RST]  = LVL_TOP;
  assign ent_lvl[VEC_TRAP] = LVL_TOP;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_mask
      assign ent_lvl[VEC_BASE+g] = lvl_i[LVL_W*g +: LVL_W];
      assign elig[VEC_BASE+g]    = pend_i[VEC_BASE+g] && en_i[g] &&
                                   (lvl_i[LVL_W*g +: LVL_W] > cur_i);
    end
  endgenerate

  // walk in hardware order; a later entry replaces only on a strictly higher level
  always_comb begin
    hit_o = 1'b0;
    vec_o = '0;
    lvl_o = '0;
    for (int j = 0; j < TOTAL; j++) begin
      if (elig[j] && (!hit_o || (ent_lvl[j] > lvl_o))) begin
        hit_o = 1'b1;
        vec_o = VEC_W'(j);
        lvl_o = ent_lvl[j];
      end
    end
  end
endmodule

// File: rtl/nipa_level.sv
module nipa_level
  import nipa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  lvl_t take_lvl_i,
  input  logic restore_i,
  input  lvl_t restore_lvl_i,
  output lvl_t cur_o
);
  lvl_t cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_q <= LVL_TOP;
    else if (take_i)    cur_q <= take_lvl_i;
    else if (restore_i) cur_q <= restore_lvl_i;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/nipa_top.sv
module nipa_top
  import nipa_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int VEC_W   = $clog2(NUM_SRC + VEC_BASE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reset_req,
  input  logic                     trap_req,
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC-1:0]       irq_en,
  input  logic [LVL_W*NUM_SRC-1:0] irq_lvl,
  input  logic                     restore_valid,
  input  logic [LVL_W-1:0]         restore_lvl,
  input  logic                     svc_ready,
  output logic                     svc_valid,
  output logic [VEC_W-1:0]         svc_vec,
  output logic [LVL_W-1:0]         svc_lvl,
  output logic                     svc_stack,
  output logic                     wake,
  output logic [LVL_W-1:0]         cur_lvl
);
  localparam int TOTAL = NUM_SRC + VEC_BASE;
  localparam logic [TOTAL-1:0] PEND_RST = TOTAL'(1) << VEC_RST;

  logic [TOTAL-1:0] set_vec, clr_vec, pend;
  logic             accept;
  lvl_t             cur_q, win_lvl;

  assign set_vec = {irq_req, trap_req, reset_req};
  assign accept  = svc_valid && svc_ready;

  genvar g;
  generate
    for (g = 0; g < TOTAL; g++) begin : g_clr
      assign clr_vec[g] = accept && (svc_vec == VEC_W'(g));
    end
  endgenerate

  nipa_pending #(.WIDTH(TOTAL), .RST_VAL(PEND_RST)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend)
  );

  nipa_select #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_sel (
    .pend_i(pend), .en_i(irq_en), .lvl_i(irq_lvl), .cur_i(cur_q),
    .hit_o(svc_valid), .vec_o(svc_vec), .lvl_o(win_lvl)
  );

  nipa_level u_lvl (
    .clk(clk), .rst_n(rst_n), .take_i(accept), .take_lvl_i(win_lvl),
    .restore_i(restore_valid), .restore_lvl_i(restore_lvl), .cur_o(cur_q)
  );

  assign svc_lvl   = win_lvl;
  assign svc_stack = svc_valid && (svc_vec != VEC_W'(VEC_RST));
  assign wake      = pend[VEC_RST] | pend[VEC_TRAP];
  assign cur_lvl   = cur_q;
endmodule

// File: rtl/nipa_chk.sv
module nipa_chk #(
  parameter int NUM_SRC = 6,
  parameter int VEC_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trap_req,
  input logic                 restore_valid,
  input logic [1:0]           restore_lvl,
  input logic                 svc_ready,
  input logic                 svc_valid,
  input logic [VEC_W-1:0]     svc_vec,
  input logic [1:0]           svc_lvl,
  input logic                 svc_stack,
  input logic                 wake,
  input logic [1:0]           cur_lvl
);
  AST_STACK_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (svc_stack == (svc_vec != '0))); // R5
  AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_vec < VEC_W'(2)) |-> svc_lvl == 2'd3); // R6
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_vec >= VEC_W'(2)) |-> svc_lvl > cur_lvl); // R3
  AST_LEVEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_ready) |=> cur_lvl == $past(svc_lvl)); // R6
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_valid && !(svc_valid && svc_ready)) |=> cur_lvl == $past(restore_lvl)); // R8
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_valid && !(svc_valid && svc_ready)) |=> $stable(cur_lvl)); // R10
  AST_WAKE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (svc_valid && svc_vec < VEC_W'(2))); // R7
  AST_TRAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> wake); // R4
endmodule

bind nipa_top nipa_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/nipa_top_bench.sv
`timescale 1ns/1ps
module nipa_top_bench;
  localparam int N     = 6;
  localparam int TOTAL = N + 2;
  localparam int VW    = $clog2(TOTAL);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reset_req = 1'b0, trap_req = 1'b0;
  logic [N-1:0]   irq_req = '0, irq_en = '0;
  logic [2*N-1:0] irq_lvl = '0;
  logic           restore_valid = 1'b0;
  logic [1:0]     restore_lvl = '0;
  logic           svc_ready = 1'b0;
  logic           svc_valid, svc_stack, wake;
  logic [VW-1:0]  svc_vec;
  logic [1:0]     svc_lvl, cur_lvl;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit   pend_m [TOTAL];
  int   cur_m;

  always #4 clk = ~clk;

  nipa_top #(.NUM_SRC(N)) u_nipa_top (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL [%s] %s actual=%0d expected=%0d at %0t", phase, tag, act, exp, $time);
    end
  endtask

  function automatic int src_lvl(int i);
    return int'(irq_lvl[2*i +: 2]);
  endfunction

  // compare outputs with the model, then advance the model over the next edge
  task automatic step();
    int best, bl, lv;
    bit el, acc;
    #1;
    best = -1; bl = -1;
    for (int j = 0; j < TOTAL; j++) begin
      lv = (j < 2) ? 3 : src_lvl(j - 2);
      el = pend_m[j] && ((j < 2) || (irq_en[j-2] && lv > cur_m));
      if (el && lv > bl) begin best = j; bl = lv; end
    end
    chk("R2 svc_valid", int'(svc_valid), int'(best >= 0));
    if (best >= 0) begin
      chk(best >= 2 ? "R3 svc_vec" : "R2 svc_vec", int'(svc_vec), best);
      chk("R6 svc_lvl", int'(svc_lvl), bl);
      chk("R5 svc_stack", int'(svc_stack), int'(best != 0));
    end
    chk("R7 wake", int'(wake), int'(pend_m[0] || pend_m[1]));
    chk("R8 cur_lvl", int'(cur_lvl), cur_m);
    acc = (best >= 0) && svc_ready;
    if (acc) pend_m[best] = 1'b0;
    if (reset_req) pend_m[0] = 1'b1;
    if (trap_req)  pend_m[1] = 1'b1;
    for (int i = 0; i < N; i++) if (irq_req[i]) pend_m[i+2] = 1'b1;
    if (acc) cur_m = bl;
    else if (restore_valid) cur_m = int'(restore_lvl);
    @(posedge clk);
    @(negedge clk);
    reset_req = 1'b0; trap_req = 1'b0; irq_req = '0; restore_valid = 1'b0;
  endtask

  task automatic set_lvl(int i, int v);
    irq_lvl[2*i +: 2] = 2'(v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int j = 0; j < TOTAL; j++) pend_m[j] = 1'b0;
    pend_m[0] = 1'b1;
    cur_m = 3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset vector offered, no stacking
    #1;
    chk("R1 valid", int'(svc_valid), 1);
    chk("R1 vec", int'(svc_vec), 0);
    chk("R1 stack", int'(svc_stack), 0);
    chk("R1 cur", int'(cur_lvl), 3);
    step();
    phase = "R10";
    step();                             // held, not accepted
    svc_ready = 1'b1; step();           // accept reset
    svc_ready = 1'b0;
    phase = "R8";
    restore_valid = 1'b1; restore_lvl = 2'd0; step();

    irq_en = '1;
    set_lvl(0, 1); set_lvl(1, 2); set_lvl(2, 2); set_lvl(3, 3); set_lvl(4, 1); set_lvl(5, 0);
    phase = "R2";
    irq_req = 6'b000101; step();        // src0 lvl1, src2 lvl2
    step();
    irq_req = 6'b000010; step();        // src1 ties src2 at lvl2
    step();
    svc_ready = 1'b1; step();           // take src1 -> level 2
    svc_ready = 1'b0;
    phase = "R3";
    step(); step();                     // equal level must not pass
    phase = "R7";
    trap_req = 1'b1; step();
    step();
    svc_ready = 1'b1; step();
    svc_ready = 1'b0;
    phase = "R8";
    restore_valid = 1'b1; restore_lvl = 2'd0; step();
    step();
    phase = "R4";
    svc_ready = 1'b1; irq_req = 6'b000100; step();   // re-request in accept cycle
    svc_ready = 1'b0;
    restore_valid = 1'b1; restore_lvl = 2'd0; step();
    step();
    phase = "R8";
    svc_ready = 1'b1; restore_valid = 1'b1; restore_lvl = 2'd1; step(); // accept wins
    svc_ready = 1'b0;
    phase = "R9";
    restore_valid = 1'b1; restore_lvl = 2'd0; irq_en = 6'b101111; irq_req = 6'b010000; step();
    svc_ready = 1'b1; step(); step(); step();
    svc_ready = 1'b0;
    irq_en = '1; step();
    svc_ready = 1'b1; step(); step();
    phase = "R1";
    svc_ready = 1'b0; reset_req = 1'b1; restore_valid = 1'b1; restore_lvl = 2'd0; step();
    step();
    svc_ready = 1'b1; step();

    phase = "R2 random";
    for (int c = 0; c < 4000; c++) begin
      irq_req   = N'($urandom) & N'($urandom);
      trap_req  = ($urandom % 23) == 0;
      reset_req = ($urandom % 97) == 0;
      svc_ready = ($urandom % 3) != 0;
      restore_valid = ($urandom % 5) == 0;
      restore_lvl   = 2'($urandom);
      if (($urandom % 16) == 0) irq_en  = N'($urandom);
      if (($urandom % 32) == 0) irq_lvl = (2*N)'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule